// File: doc/BRIEF.md
# Four-Lane Comma-Framed Link Distributor

The block takes two 32-bit parallel words per clock and spreads them over four lanes of 16 bits each. Each lane feeds an external serializer that does the 8b/10b coding, at 1.6 Gb/s per lane for an 80 MHz word clock. Every lane word comes with a 2-bit character flag, one bit per byte, that tells the serializer which bytes are control characters. The block inserts comma characters so that each receiver can find word boundaries. It does this in three cases: when an input port has nothing valid to send, when a lane has gone too long without a comma, and while a resynchronisation command from the timing receiver is active.

A small state machine tracks that command. It has two states. `ST_ALIGN` is the reset state, and the block stays in it while `sync_req` is high. `ST_RUN` is normal traffic. The transition *enter_align* (`ST_RUN` to `ST_ALIGN`) is taken on the first cycle `sync_req` is high. The transition *leave_align* (`ST_ALIGN` to `ST_RUN`) is taken on the first cycle it is low. Either state holds while `sync_req` keeps its level.

Each lane then picks one of four word kinds: align, idle, forced comma or data. It holds an 8-bit count of data words sent since its last comma. All lane outputs are registered, so each output reflects the inputs of the previous clock edge.

Top module: `lane_framer_top`

## Requirements
- R1: While `rst_n` is low, every lane outputs the align word `16'h4ABC` with flag `2'b01`, and `lane_drop` is 0.
- R2: One cycle after input, the lanes carry these halves. Lane 0 (`lane_data[15:0]`) carries `p0_data[15:0]`. Lane 1 (`[31:16]`) carries `p0_data[31:16]`. Lane 2 (`[47:32]`) carries `p1_data[15:0]`. Lane 3 (`[63:48]`) carries `p1_data[31:16]`. Lane i's flag is `lane_k[2i+1:2i]` and its drop bit is `lane_drop[i]`.
- R3: A lane that sends a data word shows flag `2'b00` for it.
- R4: When a port's valid is low and no sync is active, both of that port's lanes send the idle word `16'hB5BC` with flag `2'b01`. The low byte 0xBC is K28.5 and the high byte 0xB5 is a data byte. The other port is not affected.
- R5: While `sync_req` is high, all four lanes send `16'hB5BC`'s align counterpart `16'h4ABC` with flag `2'b01`, whatever the valid inputs are. The low byte is K28.5 and the high byte 0x4A is a fixed data byte.
- R6: On the first cycle `sync_req` is low again, every lane with valid input sends data in that same cycle.
- R7: When a lane has sent 255 data words since its last comma and its port is valid again, it sends the idle word in place of that input. `lane_drop` for that lane is 1 in the same output cycle.
- R8: Any comma a lane sends (align, idle or forced) restarts its data count from zero.
- R9: Sync, and then idle, take priority over a due forced comma. Neither of them raises `lane_drop`.
- R10: `lane_drop` is 1 only in an output cycle that carries a forced comma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req | input | 1 | Resynchronisation command from the timing receiver |
| p0_valid | input | 1 | Port 0 word is valid |
| p0_data | input | 32 | Port 0 word |
| p1_valid | input | 1 | Port 1 word is valid |
| p1_data | input | 32 | Port 1 word |
| lane_data | output | 64 | Four 16-bit lane words, lane i at bits [16i+15:16i] |
| lane_k | output | 8 | Per-byte control flags, lane i at bits [2i+1:2i] |
| lane_drop | output | 4 | Per-lane flag: the input word of this cycle was replaced by a forced comma |

## Verification
Three things can come due on a lane in the same cycle: a forced comma, a sync command and an idle input. The bench provokes each overlap deliberately. It runs 255 unbroken data words so that a lane's count reaches its limit. On the next cycle it raises `sync_req` once, and on another occasion drops the port's valid instead. The scoreboard model expects the align or idle word with no drop flag in those cycles. It also expects the lane's next comma to be spaced 256 words from that point, which confirms that the count restarted.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    localparam logic [7:0] K28_5_BYTE = 8'hBC;
    localparam logic [7:0] ALIGN_FILL = 8'h4A;
    localparam logic [7:0] IDLE_FILL  = 8'hB5;

    typedef enum logic [0:0] {
        ST_ALIGN = 1'b0,
        ST_RUN   = 1'b1
    } lfr_state_e;

    typedef enum logic [1:0] {
        WK_ALIGN = 2'd0,
        WK_IDLE  = 2'd1,
        WK_FORCE = 2'd2,
        WK_DATA  = 2'd3
    } lfr_kind_e;

endpackage

// File: rtl/lfr_sync_fsm.sv
module lfr_sync_fsm
    import lfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_req,
    output logic align_o
);

    lfr_state_e st_q;
    lfr_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ALIGN: st_d = sync_req ? ST_ALIGN : ST_RUN;
            ST_RUN:   st_d = sync_req ? ST_ALIGN : ST_RUN;
            default:  st_d = ST_ALIGN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_ALIGN;
        else        st_q <= st_d;
    end

    always_comb begin
        align_o = (st_d == ST_ALIGN);
    end

    // R5: a sync command leaves the machine in the align state
    a_r5_enter_align: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (st_q == ST_ALIGN));
    // R6: a released command returns to traffic at once
    a_r6_leave_align: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_req |=> (st_q == ST_RUN));

endmodule

// File: rtl/lfr_lane_cell.sv
module lfr_lane_cell
    import lfr_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                align_i,
    input  logic                valid_i,
    input  logic [LANE_W-1:0]   data_i,
    output logic [LANE_W-1:0]   word_o,
    output logic [LANE_W/8-1:0] k_o,
    output logic                drop_o
);

    localparam int BYTES = LANE_W / 8;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [LANE_W-1:0] ALIGN_WORD = {{(BYTES-1){ALIGN_FILL}}, K28_5_BYTE};
    localparam logic [LANE_W-1:0] IDLE_WORD  = {{(BYTES-1){IDLE_FILL}}, K28_5_BYTE};
    localparam logic [BYTES-1:0]  COMMA_K    = {{(BYTES-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    lfr_kind_e         kind;
    logic [LANE_W-1:0] word_d;
    logic [BYTES-1:0]  k_d;
    logic              drop_d;

    always_comb begin
        if (align_i)               kind = WK_ALIGN;
        else if (!valid_i)         kind = WK_IDLE;
        else if (cnt_q == CNT_MAX) kind = WK_FORCE;
        else                       kind = WK_DATA;
    end

    always_comb begin
        word_d = IDLE_WORD;
        k_d    = COMMA_K;
        drop_d = 1'b0;
        cnt_d  = '0;
        unique case (kind)
            WK_ALIGN: word_d = ALIGN_WORD;
            WK_IDLE:  word_d = IDLE_WORD;
            WK_FORCE: drop_d = 1'b1;
            WK_DATA: begin
                word_d = data_i;
                k_d    = '0;
                cnt_d  = cnt_q + 1'b1;
            end
            default: word_d = IDLE_WORD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_o <= ALIGN_WORD;
            k_o    <= COMMA_K;
            drop_o <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            word_o <= word_d;
            k_o    <= k_d;
            drop_o <= drop_d;
        end
    end

    // R5
    a_r5_align_word: assert property (@(posedge clk) disable iff (!rst_n)
        align_i |=> (word_o == ALIGN_WORD && k_o == COMMA_K && !drop_o));
    // R4, R9
    a_r4_idle_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_i && !valid_i) |=> (word_o == IDLE_WORD && k_o == COMMA_K && !drop_o));
    // R2, R3
    a_r3_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_i && valid_i && cnt_q != CNT_MAX) |=> (word_o == $past(data_i) && k_o == '0));
    // R7
    a_r7_forced_comma: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_i && valid_i && cnt_q == CNT_MAX) |=> (drop_o && word_o == IDLE_WORD));
    // R10
    a_r10_drop_is_comma: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> (word_o == IDLE_WORD && k_o == COMMA_K));
    // R8
    a_r8_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (k_o == COMMA_K) |-> (cnt_q == '0));

endmodule

// File: rtl/lane_framer_top.sv
module lane_framer_top
    import lfr_pkg::*;
#(
    parameter int PORT_W = 32,
    parameter int LANE_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sync_req,
    input  logic                       p0_valid,
    input  logic [PORT_W-1:0]          p0_data,
    input  logic                       p1_valid,
    input  logic [PORT_W-1:0]          p1_data,
    output logic [2*PORT_W-1:0]        lane_data,
    output logic [2*PORT_W/8-1:0]      lane_k,
    output logic [2*PORT_W/LANE_W-1:0] lane_drop
);

    localparam int N_PORTS        = 2;
    localparam int LANES_PER_PORT = PORT_W / LANE_W;
    localparam int N_LANES        = N_PORTS * LANES_PER_PORT;
    localparam int BYTES          = LANE_W / 8;

    logic              align;
    logic [PORT_W-1:0] port_data  [N_PORTS];
    logic              port_valid [N_PORTS];

    assign port_data[0]  = p0_data;
    assign port_data[1]  = p1_data;
    assign port_valid[0] = p0_valid;
    assign port_valid[1] = p1_valid;

    lfr_sync_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_req (sync_req),
        .align_o  (align)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int PORT = g / LANES_PER_PORT;
        localparam int PART = g % LANES_PER_PORT;

        lfr_lane_cell #(
            .LANE_W (LANE_W),
            .CNT_W  (CNT_W)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .align_i (align),
            .valid_i (port_valid[PORT]),
            .data_i  (port_data[PORT][PART*LANE_W +: LANE_W]),
            .word_o  (lane_data[g*LANE_W +: LANE_W]),
            .k_o     (lane_k[g*BYTES +: BYTES]),
            .drop_o  (lane_drop[g])
        );
    end

    // R9: no drop while the command holds
    a_r9_no_drop_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (lane_drop == '0));
    // R6: first cycle after release carries port data
    a_r6_resume_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sync_req) && p0_valid) |=> (lane_data[LANE_W-1:0] == $past(p0_data[LANE_W-1:0])));

endmodule

// File: tb/lane_framer_top_tb.sv
`timescale 1ns/1ps
module lane_framer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sync_req;
    logic        p0_valid, p1_valid;
    logic [31:0] p0_data, p1_data;
    logic [63:0] lane_data;
    logic [7:0]  lane_k;
    logic [3:0]  lane_drop;

    always #2 clk = ~clk;

    lane_framer_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_req  (sync_req),
        .p0_valid  (p0_valid),
        .p0_data   (p0_data),
        .p1_valid  (p1_valid),
        .p1_data   (p1_data),
        .lane_data (lane_data),
        .lane_k    (lane_k),
        .lane_drop (lane_drop)
    );

    typedef struct {
        logic [63:0] d;
        logic [7:0]  k;
        logic [3:0]  drop;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    int   cnt_m[4];
    bit   done = 1'b0;

    task automatic compare(input string tag, input logic [63:0] d,
                           input logic [7:0] k, input logic [3:0] drop);
        n_run++;
        if (lane_data !== d || lane_k !== k || lane_drop !== drop) begin
            n_fail++;
            $display("FAIL %s: data=%h k=%b drop=%b expected data=%h k=%b drop=%b",
                     tag, lane_data, lane_k, lane_drop, d, k, drop);
        end
    endtask

    task automatic drive(input bit s, input bit v0, input logic [31:0] d0,
                         input bit v1, input logic [31:0] d1, input string tag);
        exp_t e;
        bit   forced = 1'b0;
        @(negedge clk);
        sync_req = s; p0_valid = v0; p0_data = d0; p1_valid = v1; p1_data = d1;
        e.d = '0; e.k = '0; e.drop = '0;
        for (int i = 0; i < 4; i++) begin
            bit          v = (i < 2) ? v0 : v1;
            logic [15:0] h = (i < 2) ? ((i == 0) ? d0[15:0] : d0[31:16])
                                     : ((i == 2) ? d1[15:0] : d1[31:16]);
            if (s) begin
                e.d[i*16 +: 16] = 16'h4ABC; e.k[i*2 +: 2] = 2'b01; cnt_m[i] = 0;
            end else if (!v) begin
                e.d[i*16 +: 16] = 16'hB5BC; e.k[i*2 +: 2] = 2'b01; cnt_m[i] = 0;
            end else if (cnt_m[i] == 255) begin
                e.d[i*16 +: 16] = 16'hB5BC; e.k[i*2 +: 2] = 2'b01; cnt_m[i] = 0;
                e.drop[i] = 1'b1; forced = 1'b1;
            end else begin
                e.d[i*16 +: 16] = h; e.k[i*2 +: 2] = 2'b00; cnt_m[i]++;
            end
        end
        e.tag = forced ? {tag, " R7 R10"} : tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            compare(e.tag, e.d, e.k, e.drop);
        end
    end

    function automatic logic [31:0] pat(input int n, input int salt);
        return (n * 32'h9E37_79B9) ^ (salt * 32'h0101_0101) ^ 32'h5A5A_0F0F;
    endfunction

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) cnt_m[i] = 0;
        rst_n = 1'b0; sync_req = 1'b0; p0_valid = 1'b0; p1_valid = 1'b0;
        p0_data = '0; p1_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset", {4{16'h4ABC}}, {4{2'b01}}, 4'b0000);
        rst_n = 1'b1;

        // R2, R3: mapping with distinct patterns
        drive(0, 1, 32'h1111_2222, 1, 32'h3333_4444, "R2 R3");
        drive(0, 1, 32'hFFFF_0000, 1, 32'h0000_FFFF, "R2 R3");
        drive(0, 1, 32'hDEAD_BEEF, 1, 32'hCAFE_F00D, "R2 R3");
        drive(0, 1, 32'h00BC_BC00, 1, 32'h8001_7FFE, "R2 R3");
        // R4: idle per port, independently
        drive(0, 0, 32'hAAAA_AAAA, 1, 32'h1234_5678, "R4");
        drive(0, 1, 32'h8765_4321, 0, 32'h5555_5555, "R4");
        drive(0, 0, 32'h0, 0, 32'h0, "R4");
        // R5: sync overrides valid input
        drive(1, 1, 32'h0BAD_0BAD, 1, 32'h0BAD_0BAD, "R5");
        drive(1, 0, 32'h0, 1, 32'h7777_8888, "R5");
        drive(1, 1, 32'h0BAD_0BAD, 0, 32'h0, "R5");
        // R6: data resumes on release
        drive(0, 1, 32'h0102_0304, 1, 32'h0506_0708, "R6");
        // R7, R8: long run reaches forced comma, then restarts
        for (int n = 0; n < 600; n++)
            drive(0, 1, pat(n, 1), 1, pat(n, 2), "R8 run");
        // idle on port 1 mid-run restarts only its lanes (R8)
        drive(0, 1, pat(1, 3), 0, 32'h0, "R8 idle");
        for (int n = 0; n < 300; n++)
            drive(0, 1, pat(n, 4), 1, pat(n, 5), "R8 skew");
        // R9: sync when a forced comma is due
        drive(1, 1, 32'h0, 1, 32'h0, "R5 pre");
        for (int n = 0; n < 255; n++)
            drive(0, 1, pat(n, 6), 1, pat(n, 7), "R3 fill");
        drive(1, 1, pat(0, 8), 1, pat(1, 8), "R9 sync");
        for (int n = 0; n < 255; n++)
            drive(0, 1, pat(n, 9), 1, pat(n, 10), "R3 fill");
        drive(0, 0, 32'h0, 0, 32'h0, "R9 idle");
        for (int n = 0; n < 258; n++)
            drive(0, 1, pat(n, 11), 1, pat(n, 12), "R8 after idle");

        drive(0, 0, 32'h0, 0, 32'h0, "R4 tail");
        repeat (3) @(posedge clk);
        #2;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule